// File: doc/BRIEF.md
# Grouped Prescaler and Divider Tick Generator

This block turns one base clock into five per-channel tick enables for a bank of timer channels. Two 8-bit prescalers each divide the base rate by their programmed value plus one. The first serves channels 0 and 1. The second serves channels 2, 3 and 4. Each prescaler also advances a small binary chain, and each channel taps that chain to apply a further power-of-two division.

Every channel has a 4-bit select code. The code picks one of these divisions, starting at a base exponent that is fixed when the block is built. A build-time mask can instead mark some codes as "external". A channel set to an external code takes its ticks from its group's external clock input. That input is synchronized and edge-detected inside the block. The timer channels that consume the ticks are outside this block.

Top module: `tmr_tick_gen`

## Requirements
- R1: `tick_o` is all zero while `rst_ni` is low, and in the first cycle after reset is released.
- R2: Prescaler 0 is `pre_cfg_i[7:0]` and prescaler 1 is `pre_cfg_i[15:8]`. A value P divides the base rate by P+1. Channels 0 and 1 use prescaler 0. Channels 2 to 4 use prescaler 1.
- R3: The select code S of channel c is `div_cfg_i[4c+3:4c]`. When S is not external and S+DIV_BASE is at most 4, the channel ticks once every (P+1)·2^(S+DIV_BASE) cycles.
- R4: A non-external code with S+DIV_BASE greater than 4 divides by 16, which is the largest division.
- R5: A code whose bit is set in EXT_MASK selects the external clock. Channels 0 and 1 follow `ext_clk_i[0]`. Channels 2 to 4 follow `ext_clk_i[1]`. A rise of the input that is driven between two clock edges gives one tick in the cycle after the third following edge. A channel ignores the other group's external input.
- R6: Each tick lasts exactly one cycle. The only exception is an overall division of 1, where the tick stays high.
- R7: A new prescaler value takes effect at the next reload. The interval already counting completes with the old value.
- R8: Channels in the same group that carry the same select code tick in the same cycles.
- R9: With DIV_BASE=1, code S divides by 2^(S+1), and the same fallback to 16 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pre_cfg_i | input | 16 | Two prescaler values, group 0 in the low byte |
| div_cfg_i | input | 20 | Five 4-bit select codes, channel c at bit 4c |
| ext_clk_i | input | 2 | Asynchronous external clocks, one per group |
| tick_o | output | 5 | One-cycle tick enable per channel |

## Verification
On every cycle, the assertions check four things: the outputs are quiet right after reset, a tick never repeats while its configuration is steady and its division exceeds one, same-code channels of a group stay in lockstep, and an external channel stays silent when its input was low. Only the directed scenarios show the following: the actual interval lengths for each prescaler, code and fallback; the exact three-edge latency of the external path; the deferred adoption of a new prescaler value; and the behaviour of the alternate base exponent.

// File: rtl/tick_pkg.sv
// Shared helpers for the tick generator: group mapping and exponent decoding.
// Assumes two channel groups; the first GRP0_CH channels belong to group 0.
package tick_pkg;

    localparam int NUM_GRP = 2;

    // Group index of a channel given the size of group 0.
    function automatic int grp_of(input int ch, input int grp0_n);
        return (ch < grp0_n) ? 0 : 1;
    endfunction

    // Power-of-two exponent for a select code, clipped to the largest division.
    function automatic int div_exp(input int code, input int base, input int lim);
        int e;
        e = code + base;
        return (e > lim) ? lim : e;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Group prescaler: a down counter that reloads the programmed value and
// flags one cycle at zero, plus a binary chain counting those flags.
// Assumes the programmed value may change at any time; it is taken at reload.
module tick_prescaler #(
    parameter int PRE_W    = 8,
    parameter int LOG2_MAX = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [PRE_W-1:0]    pre_val_i,
    output logic                pre_tick_o,
    output logic [LOG2_MAX-1:0] chain_o
);

    logic [PRE_W-1:0]    cnt_q;
    logic [LOG2_MAX-1:0] chain_q;

    assign pre_tick_o = (cnt_q == '0);
    assign chain_o    = chain_q;

    // Count down; on zero load the current prescaler value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (pre_tick_o) begin
            cnt_q <= pre_val_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Advance the power-of-two chain once per prescaler output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else if (pre_tick_o) begin
            chain_q <= chain_q + 1'b1;
        end
    end

endmodule

// File: rtl/tick_ext_sync.sv
// External clock conditioner: STAGES flip-flops of synchronization followed
// by a rising-edge detector. Assumes the input is slower than half clk_i.
module tick_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    output logic ext_tick_o
);

    logic [STAGES:0] sh_q;

    // Shift the asynchronous input through the synchronizer and one history bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], ext_i};
        end
    end

    assign ext_tick_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/tick_chan_sel.sv
// Per-channel selector: decodes the select code into a chain tap or the
// external tick and registers the result. Assumes chain_i advances only
// on pre_tick_i.
module tick_chan_sel
    import tick_pkg::*;
#(
    parameter int                  SEL_W    = 4,
    parameter int                  LOG2_MAX = 4,
    parameter int                  DIV_BASE = 0,
    parameter logic [2**SEL_W-1:0] EXT_MASK = '0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                pre_tick_i,
    input  logic [LOG2_MAX-1:0] chain_i,
    input  logic                ext_tick_i,
    output logic                tick_o
);

    int                  exp_w;
    logic [LOG2_MAX-1:0] low_mask;
    logic                div_hit;
    logic                use_ext;
    logic                tick_q;

    // Decode the code into the chain bits that must all be set.
    always_comb begin
        exp_w    = div_exp(int'(sel_i), DIV_BASE, LOG2_MAX);
        low_mask = LOG2_MAX'((1 << exp_w) - 1);
        div_hit  = pre_tick_i && ((chain_i & low_mask) == low_mask);
        use_ext  = EXT_MASK[sel_i];
    end

    // Register the chosen tick source.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= use_ext ? ext_tick_i : div_hit;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/tmr_tick_gen.sv
// Tick generator top: two group prescalers, two external conditioners and
// one selector per channel. Assumes configuration inputs are synchronous
// to clk_i; ext_clk_i may be asynchronous.
module tmr_tick_gen
    import tick_pkg::*;
#(
    parameter int                  NUM_CH   = 5,
    parameter int                  GRP0_CH  = 2,
    parameter int                  PRE_W    = 8,
    parameter int                  SEL_W    = 4,
    parameter int                  DIV_BASE = 0,
    parameter int                  LOG2_MAX = 4,
    parameter int                  SYNC_N   = 2,
    parameter logic [2**SEL_W-1:0] EXT_MASK = 16'h00E0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_GRP*PRE_W-1:0]    pre_cfg_i,
    input  logic [NUM_CH*SEL_W-1:0]     div_cfg_i,
    input  logic [NUM_GRP-1:0]          ext_clk_i,
    output logic [NUM_CH-1:0]           tick_o
);

    logic [NUM_GRP-1:0]  pre_tick;
    logic [LOG2_MAX-1:0] chain [NUM_GRP];
    logic [NUM_GRP-1:0]  ext_tick;

    // One prescaler and one external conditioner per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tick_prescaler #(
            .PRE_W    (PRE_W),
            .LOG2_MAX (LOG2_MAX)
        ) u_pre (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pre_val_i  (pre_cfg_i[g*PRE_W +: PRE_W]),
            .pre_tick_o (pre_tick[g]),
            .chain_o    (chain[g])
        );

        tick_ext_sync #(
            .STAGES (SYNC_N)
        ) u_ext (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ext_i      (ext_clk_i[g]),
            .ext_tick_o (ext_tick[g])
        );
    end

    // One selector per channel, wired to its group's sources.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = grp_of(c, GRP0_CH);

        tick_chan_sel #(
            .SEL_W    (SEL_W),
            .LOG2_MAX (LOG2_MAX),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) u_sel (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sel_i      (div_cfg_i[c*SEL_W +: SEL_W]),
            .pre_tick_i (pre_tick[GRP]),
            .chain_i    (chain[GRP]),
            .ext_tick_i (ext_tick[GRP]),
            .tick_o     (tick_o[c])
        );
    end

endmodule

// File: rtl/tmr_tick_gen_chk.sv
// Property checker for the tick generator, bound to every instance.
// Assumes the same parameters as the instance it observes.
module tmr_tick_gen_chk
    import tick_pkg::*;
#(
    parameter int                  NUM_CH   = 5,
    parameter int                  GRP0_CH  = 2,
    parameter int                  PRE_W    = 8,
    parameter int                  SEL_W    = 4,
    parameter logic [2**SEL_W-1:0] EXT_MASK = 16'h00E0
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_GRP*PRE_W-1:0] pre_cfg_i,
    input logic [NUM_CH*SEL_W-1:0]  div_cfg_i,
    input logic [NUM_GRP-1:0]       ext_clk_i,
    input logic [NUM_CH-1:0]        tick_o
);

    logic [2:0]        cyc_q;
    logic [NUM_CH-1:0] ext_sel;

    // Count cycles since reset release, saturating, to guard $past lookups.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cyc_q <= '0;
        end else if (cyc_q != 3'd4) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    a_r1_post_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q == 3'd0) |-> (tick_o == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int GRP = grp_of(c, GRP0_CH);

        assign ext_sel[c] = EXT_MASK[div_cfg_i[c*SEL_W +: SEL_W]];

        a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cyc_q >= 3'd2 && tick_o[c] && $stable(pre_cfg_i) && $stable(div_cfg_i)
             && (ext_sel[c] || pre_cfg_i[GRP*PRE_W +: PRE_W] != '0))
            |=> !tick_o[c]);

        a_r5_ext_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cyc_q >= 3'd3 && $past(ext_sel[c]) && !$past(ext_clk_i[GRP], 3))
            |-> !tick_o[c]);

        if (c + 1 < NUM_CH && grp_of(c + 1, GRP0_CH) == GRP) begin : g_pair
            a_r8_group_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (cyc_q >= 3'd2 && $stable(div_cfg_i)
                 && div_cfg_i[c*SEL_W +: SEL_W] == div_cfg_i[(c+1)*SEL_W +: SEL_W])
                |-> (tick_o[c] == tick_o[c+1]));
        end
    end

endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(
    .NUM_CH   (NUM_CH),
    .GRP0_CH  (GRP0_CH),
    .PRE_W    (PRE_W),
    .SEL_W    (SEL_W),
    .EXT_MASK (EXT_MASK)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_cfg_i (pre_cfg_i),
    .div_cfg_i (div_cfg_i),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick_o)
);

// File: tb/tmr_tick_gen_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tmr_tick_gen_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] pre_cfg = '0;
    logic [19:0] div_cfg = '0;
    logic [1:0]  ext_clk = '0;
    logic [4:0]  tick_a;
    logic [4:0]  tick_b;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk_i = ~clk_i;

    tmr_tick_gen dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pre_cfg_i (pre_cfg),
        .div_cfg_i (div_cfg),
        .ext_clk_i (ext_clk),
        .tick_o    (tick_a)
    );

    tmr_tick_gen #(
        .DIV_BASE (1),
        .EXT_MASK (16'h0010)
    ) dut_b_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pre_cfg_i (pre_cfg),
        .div_cfg_i (div_cfg),
        .ext_clk_i (ext_clk),
        .tick_o    (tick_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic tk(input bit b, input int ch);
        return b ? tick_b[ch] : tick_a[ch];
    endfunction

    // Wait for a tick, then count cycles to the next one.
    task automatic get_iv(input bit b, input int ch, output int iv);
        int n;
        n = 0;
        @(negedge clk_i);
        while (!tk(b, ch) && n < 5000) begin
            @(negedge clk_i);
            n++;
        end
        iv = 0;
        do begin
            @(negedge clk_i);
            iv++;
        end while (!tk(b, ch) && iv < 5000);
    endtask

    task automatic measure(input bit b, input int ch, input int exp, input string req);
        int iv;
        get_iv(b, ch, iv);
        get_iv(b, ch, iv);
        chk(req, $sformatf("dut%s ch%0d interval", b ? "B" : "A", ch), iv, exp);
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk_i);
        @(negedge clk_i);
        chk("R1", "ticks A in reset", int'(tick_a), 0);
        chk("R1", "ticks B in reset", int'(tick_b), 0);
        rst_ni = 1'b1;
        #1;
        chk("R1", "ticks A first cycle after release", int'(tick_a), 0);
    endtask

    task automatic t_groups;
        int mism;
        @(negedge clk_i);
        pre_cfg = {8'd4, 8'd1};
        div_cfg = 20'h00000;
        measure(0, 0, 2, "R2");
        measure(0, 1, 2, "R2");
        measure(0, 2, 5, "R2");
        measure(0, 3, 5, "R2");
        measure(0, 4, 5, "R2");
        mism = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_i);
            if (tick_a[0] != tick_a[1] || tick_a[2] != tick_a[4]) mism++;
        end
        chk("R8", "same-code group mismatches", mism, 0);
    endtask

    task automatic t_codes;
        @(negedge clk_i);
        pre_cfg = {8'd2, 8'd0};
        div_cfg = 20'h29143;
        measure(0, 0, 8, "R3");
        measure(0, 1, 16, "R3");
        measure(0, 2, 6, "R3");
        measure(0, 3, 48, "R4");
        measure(0, 4, 12, "R3");
    endtask

    task automatic t_width;
        int dbl, hi;
        bit prev;
        @(negedge clk_i);
        pre_cfg = {8'd3, 8'd0};
        div_cfg = 20'h00000;
        repeat (10) @(negedge clk_i);
        dbl = 0;
        hi = 0;
        prev = tick_a[2];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_i);
            if (prev && tick_a[2]) dbl++;
            prev = tick_a[2];
            if (tick_a[0]) hi++;
        end
        chk("R6", "back-to-back ticks on ch2", dbl, 0);
        chk("R6", "ch0 high cycles at division 1", hi, 40);
    endtask

    task automatic t_reload;
        int iv;
        @(negedge clk_i);
        pre_cfg = {8'd0, 8'd7};
        div_cfg = 20'h00000;
        get_iv(0, 0, iv);
        get_iv(0, 0, iv);
        chk("R7", "interval at P=7", iv, 8);
        pre_cfg[7:0] = 8'd2;
        iv = 0;
        do begin @(negedge clk_i); iv++; end while (!tick_a[0] && iv < 100);
        chk("R7", "interval in progress keeps old value", iv, 8);
        iv = 0;
        do begin @(negedge clk_i); iv++; end while (!tick_a[0] && iv < 100);
        chk("R7", "interval after reload", iv, 3);
    endtask

    task automatic t_ext;
        int seq1, seq3, stray;
        @(negedge clk_i);
        pre_cfg = {8'd0, 8'd0};
        div_cfg = 20'h06050;
        ext_clk = 2'b00;
        repeat (8) @(negedge clk_i);
        ext_clk[0] = 1'b1;
        seq1 = 0;
        seq3 = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_i);
            seq1 = (seq1 << 1) | int'(tick_a[1]);
            seq3 = (seq3 << 1) | int'(tick_a[3]);
        end
        chk("R5", "ch1 ext0 tick pattern", seq1, 4'b0010);
        chk("R5", "ch3 ignores ext0", seq3, 0);
        stray = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_i);
            if (tick_a[1]) stray++;
        end
        chk("R5", "ch1 ticks while ext0 held high", stray, 0);
        ext_clk[0] = 1'b0;
        repeat (6) @(negedge clk_i);
        ext_clk[1] = 1'b1;
        seq1 = 0;
        seq3 = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_i);
            seq1 = (seq1 << 1) | int'(tick_a[1]);
            seq3 = (seq3 << 1) | int'(tick_a[3]);
        end
        chk("R5", "ch3 ext1 tick pattern", seq3, 4'b0010);
        chk("R5", "ch1 ignores ext1", seq1, 0);
        ext_clk[1] = 1'b0;
        repeat (6) @(negedge clk_i);
    endtask

    task automatic t_base_one;
        int seq4;
        @(negedge clk_i);
        pre_cfg = {8'd0, 8'd1};
        div_cfg = 20'h45320;
        measure(1, 0, 4, "R9");
        measure(1, 1, 16, "R9");
        measure(1, 2, 16, "R9");
        measure(1, 3, 16, "R4");
        repeat (6) @(negedge clk_i);
        ext_clk[1] = 1'b1;
        seq4 = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_i);
            seq4 = (seq4 << 1) | int'(tick_b[4]);
        end
        chk("R9", "base-1 build ch4 external code 4", seq4, 4'b0010);
        ext_clk[1] = 1'b0;
    endtask

    initial begin
        t_reset();
        t_groups();
        t_codes();
        t_width();
        t_reload();
        t_ext();
        t_base_one();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule